// File: doc/BRIEF.md
# Interrupt Steering Aggregator

This block gathers a wide bank of level-sensitive interrupt lines and merges them into a few output lines. Each input passes through its own enable bit. Software can also force any input pending through a set bit of its own. The filtered result of each group of 64 inputs is ORed into one output line. Software finds the sources by reading the status words and scanning their set bits.

Access is through a small register bus with byte offsets that must be word aligned. A write strobe stores the data bus into the addressed register in the same clock edge. A read strobe loads the addressed register into a holding register, and that register drives the read data bus from the next cycle until the next read strobe. The 32-bit words are numbered in reverse input order: the highest word index carries inputs 0 to 31. The register map derives from NW = NUM_IN/32. The channel word is at 0x0. The enable words are at 0x4+4i and the force words at 4·NW+0x4+4i. The status words are at 8·NW+0x4+4i, the output-disable word at 12·NW+0x4 and the group summary word at 12·NW+0x8. The block is built as channel CHAN_ID and drives its outputs only while that bit of the channel word is set.

Top module: `irq_steer_agg`

## Requirements
- R1: After reset every register reads zero, every output line is low and rd_data is zero.
- R2: The enable and force words read back all 32 written bits. The channel word reads back only its low NUM_CHAN bits and the output-disable word only its low NUM_OUT bits, with the upper bits zero.
- R3: Input n appears in status word index NW−1−n/32 at bit n mod 32. With the default 128 inputs, input 0 is word 3 bit 0 at offset 0x30, and input 127 is word 0 bit 31 at offset 0x24.
- R4: A status bit is (input level OR force bit) AND enable bit, and it is recomputed every cycle. It clears as soon as the level drops while its force bit is 0, and an enable bit of 0 blocks it.
- R5: Output k is the OR of the status bits of inputs 64k to 64k+63. It is low while bit k of the output-disable word is 1 or bit CHAN_ID of the channel word is 0.
- R6: Bit k of the group summary word is the OR of group k's status bits, and it does not depend on output-disable or channel gating.
- R7: Writes to the status words, the summary word, unmapped offsets or offsets with nonzero low two bits change no register. Reads of those unmapped or misaligned offsets return zero.
- R8: rd_data takes the addressed value on the clock edge where rd_en is high and keeps it unchanged while rd_en stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IN | Level-sensitive interrupt inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Byte offset of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data held from the last read strobe |
| irq_out | output | (NUM_IN+63)/64 | Grouped output interrupt lines |

## Verification
The assertions assume that irq_in, wr_en, rd_en and addr change only away from the rising clock edge. They also assume that reset is applied before the first access. The bench meets both conditions by driving every input on the falling edge, and it keeps the strobes to one cycle per access. The random force values are made sparse so that both the empty and the busy group states are reached. The random disable values cover each gating combination, and the bench steers the channel word away from CHAN_ID to show that the summary word is independent of output gating.

// File: rtl/steer_pkg.sv
package steer_pkg;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CHAN,
        RK_ENAB,
        RK_FORCE,
        RK_STAT,
        RK_ODIS,
        RK_SUMM
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e   kind;
        logic [15:0] idx;
    } reg_sel_t;

    // Map a byte offset onto a register kind and a word index.
    function automatic reg_sel_t decode_addr(input logic [31:0] byte_addr, input int nw);
        reg_sel_t s;
        int       wa;
        s.kind = RK_NONE;
        s.idx  = '0;
        wa     = int'(byte_addr[31:2]);
        if (byte_addr[1:0] == 2'b00) begin
            if (wa == 0) begin
                s.kind = RK_CHAN;
            end else if (wa <= nw) begin
                s.kind = RK_ENAB;
                s.idx  = 16'(wa - 1);
            end else if (wa <= 2 * nw) begin
                s.kind = RK_FORCE;
                s.idx  = 16'(wa - nw - 1);
            end else if (wa <= 3 * nw) begin
                s.kind = RK_STAT;
                s.idx  = 16'(wa - 2 * nw - 1);
            end else if (wa == 3 * nw + 1) begin
                s.kind = RK_ODIS;
            end else if (wa == 3 * nw + 2) begin
                s.kind = RK_SUMM;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/steer_regs.sv
module steer_regs
    import steer_pkg::*;
#(
    parameter int NW       = 4,
    parameter int NUM_OUT  = 2,
    parameter int NUM_CHAN = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  reg_sel_t               wr_sel,
    input  logic [31:0]            wr_data,
    output logic [NUM_CHAN-1:0]    chan_q,
    output logic [NW-1:0][31:0]    enab_q,
    output logic [NW-1:0][31:0]    force_q,
    output logic [NUM_OUT-1:0]     odis_q
);

    localparam int IW = (NW > 1) ? $clog2(NW) : 1;

    logic [IW-1:0] widx;
    assign widx = wr_sel.idx[IW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q <= '0;
        end else if (wr_en && wr_sel.kind == RK_CHAN) begin
            chan_q <= wr_data[NUM_CHAN-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            odis_q <= '0;
        end else if (wr_en && wr_sel.kind == RK_ODIS) begin
            odis_q <= wr_data[NUM_OUT-1:0];
        end
    end

    for (genvar w = 0; w < NW; w++) begin : g_word
        logic hit_en;
        logic hit_fc;
        assign hit_en = wr_en && (wr_sel.kind == RK_ENAB)  && (widx == IW'(w));
        assign hit_fc = wr_en && (wr_sel.kind == RK_FORCE) && (widx == IW'(w));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                enab_q[w] <= '0;
            end else if (hit_en) begin
                enab_q[w] <= wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                force_q[w] <= '0;
            end else if (hit_fc) begin
                force_q[w] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/steer_status.sv
module steer_status #(
    parameter int NUM_IN   = 128,
    parameter int NW       = 4,
    parameter int NUM_OUT  = 2,
    parameter int NUM_CHAN = 4,
    parameter int CHAN_ID  = 1
) (
    input  logic [NUM_IN-1:0]      irq_in,
    input  logic [NW-1:0][31:0]    enab_q,
    input  logic [NW-1:0][31:0]    force_q,
    input  logic [NUM_CHAN-1:0]    chan_q,
    input  logic [NUM_OUT-1:0]     odis_q,
    output logic [NW-1:0][31:0]    stat_w,
    output logic [NUM_OUT-1:0]     summ,
    output logic [NUM_OUT-1:0]     irq_out
);

    logic chan_on;
    assign chan_on = chan_q[CHAN_ID];

    // Word w holds inputs starting at (NW-1-w)*32.
    for (genvar w = 0; w < NW; w++) begin : g_stat
        localparam int BASE = (NW - 1 - w) * 32;
        assign stat_w[w] = (irq_in[BASE +: 32] | force_q[w]) & enab_q[w];
    end

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_grp
        localparam int LO_W = NW - 1 - 2 * k;
        if (2 * k + 1 < NW) begin : g_pair
            localparam int HI_W = NW - 2 - 2 * k;
            assign summ[k] = (|stat_w[LO_W]) | (|stat_w[HI_W]);
        end else begin : g_single
            assign summ[k] = |stat_w[LO_W];
        end
        assign irq_out[k] = summ[k] & ~odis_q[k] & chan_on;
    end

endmodule

// File: rtl/steer_rdpath.sv
module steer_rdpath
    import steer_pkg::*;
#(
    parameter int NW       = 4,
    parameter int NUM_OUT  = 2,
    parameter int NUM_CHAN = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_en,
    input  reg_sel_t               rd_sel,
    input  logic [NUM_CHAN-1:0]    chan_q,
    input  logic [NW-1:0][31:0]    enab_q,
    input  logic [NW-1:0][31:0]    force_q,
    input  logic [NW-1:0][31:0]    stat_w,
    input  logic [NUM_OUT-1:0]     odis_q,
    input  logic [NUM_OUT-1:0]     summ,
    output logic [31:0]            rd_data
);

    localparam int IW = (NW > 1) ? $clog2(NW) : 1;

    logic [IW-1:0] ridx;
    logic [31:0]   rd_mux;

    assign ridx = rd_sel.idx[IW-1:0];

    always_comb begin
        rd_mux = '0;
        unique case (rd_sel.kind)
            RK_CHAN:  rd_mux = 32'(chan_q);
            RK_ENAB:  rd_mux = enab_q[ridx];
            RK_FORCE: rd_mux = force_q[ridx];
            RK_STAT:  rd_mux = stat_w[ridx];
            RK_ODIS:  rd_mux = 32'(odis_q);
            RK_SUMM:  rd_mux = 32'(summ);
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_mux;
        end
    end

endmodule

// File: rtl/irq_steer_agg.sv
module irq_steer_agg
    import steer_pkg::*;
#(
    parameter int NUM_IN   = 128,
    parameter int NUM_CHAN = 4,
    parameter int CHAN_ID  = 1,
    parameter int AW       = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_IN-1:0]             irq_in,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  logic [AW-1:0]                 addr,
    input  logic [31:0]                   wr_data,
    output logic [31:0]                   rd_data,
    output logic [(NUM_IN+63)/64-1:0]     irq_out
);

    localparam int NW      = NUM_IN / 32;
    localparam int NUM_OUT = (NUM_IN + 63) / 64;

    reg_sel_t                sel;
    logic [NUM_CHAN-1:0]     chan_q;
    logic [NW-1:0][31:0]     enab_q;
    logic [NW-1:0][31:0]     force_q;
    logic [NW-1:0][31:0]     stat_w;
    logic [NUM_OUT-1:0]      odis_q;
    logic [NUM_OUT-1:0]      summ;

    assign sel = decode_addr(32'(addr), NW);

    steer_regs #(
        .NW(NW), .NUM_OUT(NUM_OUT), .NUM_CHAN(NUM_CHAN)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(sel), .wr_data(wr_data),
        .chan_q(chan_q), .enab_q(enab_q), .force_q(force_q), .odis_q(odis_q)
    );

    steer_status #(
        .NUM_IN(NUM_IN), .NW(NW), .NUM_OUT(NUM_OUT),
        .NUM_CHAN(NUM_CHAN), .CHAN_ID(CHAN_ID)
    ) u_status (
        .irq_in(irq_in), .enab_q(enab_q), .force_q(force_q), .chan_q(chan_q),
        .odis_q(odis_q), .stat_w(stat_w), .summ(summ), .irq_out(irq_out)
    );

    steer_rdpath #(
        .NW(NW), .NUM_OUT(NUM_OUT), .NUM_CHAN(NUM_CHAN)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(sel), .chan_q(chan_q),
        .enab_q(enab_q), .force_q(force_q), .stat_w(stat_w), .odis_q(odis_q),
        .summ(summ), .rd_data(rd_data)
    );

endmodule

// File: rtl/steer_chk.sv
module steer_chk #(
    parameter int NUM_IN   = 128,
    parameter int NUM_OUT  = 2,
    parameter int NUM_CHAN = 4,
    parameter int CHAN_ID  = 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_IN-1:0]      irq_in,
    input logic                   rd_en,
    input logic [31:0]            rd_data,
    input logic [NUM_OUT-1:0]     irq_out,
    input logic [NUM_CHAN-1:0]    chan_q,
    input logic [NUM_OUT-1:0]     odis_q,
    input logic [NUM_OUT-1:0]     summ,
    input logic [NUM_IN-1:0]      force_flat
);

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_in == '0 && force_flat == '0) |-> (irq_out == '0)); // R4

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R8

    AST_OUT_NEEDS_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out != '0) |-> chan_q[CHAN_ID]); // R5

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_k
        AST_ODIS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out[k] |-> !odis_q[k]); // R5

        AST_OUT_WITHIN_SUMM: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out[k] |-> summ[k]); // R6
    end

endmodule

bind irq_steer_agg steer_chk #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .NUM_CHAN(NUM_CHAN), .CHAN_ID(CHAN_ID)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .rd_en(rd_en), .rd_data(rd_data),
    .irq_out(irq_out), .chan_q(chan_q), .odis_q(odis_q), .summ(summ),
    .force_flat(force_q)
);

// File: tb/irq_steer_agg_tb.sv
module irq_steer_agg_tb;

    localparam int NUM_IN   = 128;
    localparam int NUM_CHAN = 4;
    localparam int CHAN_ID  = 1;
    localparam int AW       = 8;
    localparam int NW       = NUM_IN / 32;
    localparam int NOUT     = (NUM_IN + 63) / 64;

    localparam logic [AW-1:0] A_CHAN = 8'h00;
    localparam logic [AW-1:0] A_ODIS = AW'(12 * NW + 4);
    localparam logic [AW-1:0] A_SUMM = AW'(12 * NW + 8);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NUM_IN-1:0]    irq_in = '0;
    logic                 wr_en = 1'b0;
    logic                 rd_en = 1'b0;
    logic [AW-1:0]        addr = '0;
    logic [31:0]          wr_data = '0;
    logic [31:0]          rd_data;
    logic [NOUT-1:0]      irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0]          enab_m [NW];
    logic [31:0]          force_m [NW];
    logic [NUM_CHAN-1:0]  chan_m;
    logic [NOUT-1:0]      odis_m;

    always #5 clk = ~clk;

    irq_steer_agg #(
        .NUM_IN(NUM_IN), .NUM_CHAN(NUM_CHAN), .CHAN_ID(CHAN_ID), .AW(AW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out)
    );

    function automatic logic [AW-1:0] a_enab(int i);  return AW'(4 + 4 * i); endfunction
    function automatic logic [AW-1:0] a_force(int i); return AW'(4 * NW + 4 + 4 * i); endfunction
    function automatic logic [AW-1:0] a_stat(int i);  return AW'(8 * NW + 4 + 4 * i); endfunction

    function automatic logic [31:0] e_stat(int w);
        int base;
        base = (NW - 1 - w) * 32;
        return (irq_in[base +: 32] | force_m[w]) & enab_m[w];
    endfunction

    function automatic logic [NOUT-1:0] e_summ();
        logic [NOUT-1:0] s;
        for (int k = 0; k < NOUT; k++) begin
            s[k] = |e_stat(NW - 1 - 2 * k);
            if (2 * k + 1 < NW) s[k] = s[k] | (|e_stat(NW - 2 - 2 * k));
        end
        return s;
    endfunction

    function automatic logic [NOUT-1:0] e_out();
        return e_summ() & ~odis_m & {NOUT{chan_m[CHAN_ID]}};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic set_enab(int i, logic [31:0] d);  bus_write(a_enab(i), d);  enab_m[i] = d;  endtask
    task automatic set_force(int i, logic [31:0] d); bus_write(a_force(i), d); force_m[i] = d; endtask
    task automatic set_chan(logic [31:0] d); bus_write(A_CHAN, d); chan_m = d[NUM_CHAN-1:0]; endtask
    task automatic set_odis(logic [31:0] d); bus_write(A_ODIS, d); odis_m = d[NOUT-1:0]; endtask

    task automatic check_all(string tag);
        logic [31:0] v;
        for (int w = 0; w < NW; w++) begin
            bus_read(a_stat(w), v);
            check({tag, " R4 status"}, v, e_stat(w));
        end
        bus_read(A_SUMM, v);
        check({tag, " R6 summary"}, v, 32'(e_summ()));
        check({tag, " R5 irq_out"}, 32'(irq_out), 32'(e_out()));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] held;
        void'($urandom(32'h1234_5678));
        for (int i = 0; i < NW; i++) begin enab_m[i] = '0; force_m[i] = '0; end
        chan_m = '0;
        odis_m = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 irq_out", 32'(irq_out), 32'h0);
        check("R1 rd_data", rd_data, 32'h0);
        for (int a = 0; a <= 12 * NW + 8; a += 4) begin
            bus_read(AW'(a), v);
            check("R1 register", v, 32'h0);
        end

        // R2: readback widths
        bus_write(A_CHAN, 32'hFFFF_FFFF);
        bus_read(A_CHAN, v);
        check("R2 channel width", v, 32'h0000_000F);
        bus_write(A_ODIS, 32'hFFFF_FFFF);
        bus_read(A_ODIS, v);
        check("R2 disable width", v, 32'h0000_0003);
        set_odis(32'h0);
        set_chan(32'(1 << CHAN_ID));
        for (int i = 0; i < NW; i++) begin
            set_enab(i, $urandom);
            set_force(i, $urandom);
        end
        for (int i = 0; i < NW; i++) begin
            bus_read(a_enab(i), v);
            check("R2 enable readback", v, enab_m[i]);
            bus_read(a_force(i), v);
            check("R2 force readback", v, force_m[i]);
        end

        // R3: word ordering
        for (int i = 0; i < NW; i++) begin set_enab(i, 32'hFFFF_FFFF); set_force(i, 32'h0); end
        irq_in = '0; irq_in[0] = 1'b1;
        bus_read(a_stat(NW - 1), v);
        check("R3 input 0 in last word", v, 32'h0000_0001);
        bus_read(a_stat(0), v);
        check("R3 word 0 empty", v, 32'h0);
        check("R3 output 0", 32'(irq_out), 32'h1);
        irq_in = '0; irq_in[NUM_IN-1] = 1'b1;
        bus_read(a_stat(0), v);
        check("R3 top input in word 0", v, 32'h8000_0000);
        irq_in = '0; irq_in[64] = 1'b1;
        bus_read(a_stat(1), v);
        check("R3 input 64 in word 1", v, 32'h0000_0001);
        check("R3 output 1", 32'(irq_out), 32'h2);

        // R4: level behaviour and enable blocking
        irq_in = '0;
        bus_read(a_stat(1), v);
        check("R4 level drop clears", v, 32'h0);
        check("R4 output drops", 32'(irq_out), 32'h0);
        set_enab(3, 32'h0);
        set_force(3, 32'h0000_0100);
        bus_read(a_stat(3), v);
        check("R4 enable blocks force", v, 32'h0);
        set_enab(3, 32'h0000_0100);
        bus_read(a_stat(3), v);
        check("R4 force pending", v, 32'h0000_0100);

        // R5/R6: gating
        set_chan(32'h1);
        check("R5 wrong channel gates", 32'(irq_out), 32'h0);
        bus_read(A_SUMM, v);
        check("R6 summary ignores channel", v, 32'h1);
        set_chan(32'(1 << CHAN_ID));
        set_odis(32'h1);
        check("R5 disable gates", 32'(irq_out), 32'h0);
        bus_read(A_SUMM, v);
        check("R6 summary ignores disable", v, 32'h1);
        set_odis(32'h0);
        check("R5 output restored", 32'(irq_out), 32'h1);

        // R7: read-only and unmapped
        bus_write(a_stat(3), 32'hFFFF_FFFF);
        bus_write(A_SUMM, 32'hFFFF_FFFF);
        bus_write(AW'(12 * NW + 12), 32'hFFFF_FFFF);
        bus_write(AW'(5), 32'hFFFF_FFFF);
        bus_read(a_stat(3), v);
        check("R7 status write ignored", v, 32'h0000_0100);
        bus_read(a_enab(0), v);
        check("R7 enable untouched", v, enab_m[0]);
        bus_read(a_enab(3), v);
        check("R7 enable untouched", v, enab_m[3]);
        bus_read(A_CHAN, v);
        check("R7 channel untouched", v, 32'(chan_m));
        bus_read(A_ODIS, v);
        check("R7 disable untouched", v, 32'(odis_m));
        bus_read(AW'(12 * NW + 12), v);
        check("R7 unmapped reads zero", v, 32'h0);
        bus_read(AW'(8'hF0), v);
        check("R7 high unmapped reads zero", v, 32'h0);
        bus_read(AW'(5), v);
        check("R7 misaligned reads zero", v, 32'h0);

        // R8: hold between reads
        bus_read(a_stat(3), v);
        held = v;
        set_force(3, 32'h0);
        irq_in = '1;
        repeat (3) @(negedge clk);
        check("R8 rd_data held", rd_data, held);
        irq_in = '0;

        // Random mix
        for (int it = 0; it < 30; it++) begin
            for (int i = 0; i < NW; i++) begin
                set_enab(i, $urandom);
                set_force(i, (it % 3 == 0) ? ($urandom & $urandom & $urandom) : 32'h0);
            end
            set_odis($urandom);
            set_chan((it % 5 == 4) ? 32'h1 : 32'(1 << CHAN_ID));
            for (int i = 0; i < NW; i++) begin
                irq_in[i*32 +: 32] = (it % 2 == 0) ? ($urandom & $urandom) : 32'h0;
            end
            check_all("rand");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule